// File: doc/BRIEF.md
# Key Event Capture with Sticky Flags

This block watches six key input lines and records a falling-edge key event on each line that is set up as a digital input. Each line has a sticky flag that software reads as one byte and clears selectively with a single 8-bit write. A combined interrupt request pulses for one cycle whenever any enabled line produces a new event, so the interrupt controller sees every key press even if a flag was already pending.

Each line passes through a two-stage synchronizer into a small per-line state machine with three states. KS_OFF means the line is not configured as a key input. KS_HIGH means the line was last seen high. KS_LOW means the line was last seen low. The transitions are:

- KS_OFF goes to KS_HIGH or KS_LOW when the line becomes enabled, following the synchronized level and raising no event.
- KS_HIGH goes to KS_LOW when the synchronized level falls. This is the only transition that raises an event.
- KS_LOW goes to KS_HIGH when the level rises.
- Any state goes to KS_OFF when the line is disabled.

A global flag-mode input decides whether flags are kept at all. With it low, the flags are held at zero, reads return zero and writes are ignored.

Top module: `keyret_capture`

## Requirements
- R1: After reset, rd_data reads 8'h00 and irq is 0.
- R2: A falling edge on an enabled line n (key_in[n] 1 to 0) sets rd_data[n] and pulses irq. Both are visible after the third rising clock edge following the input change: two synchronizer stages, then the flag and irq registers.
- R3: rd_data bits 7 and 6 always read 0. Bits 5..0 are the flags of lines 5..0.
- R4: A write (wr_en=1) clears flag n when wr_data[n] is 0 and leaves it unchanged when wr_data[n] is 1. A write of 1 never sets a flag, and a flag never clears without a write.
- R5: When an event on line n and a write with wr_data[n]=0 take effect on the same clock edge, flag n ends up set.
- R6: Line n is a key input only when pin_dir[n]=1 (input) and pin_analog[n]=0 (digital). Otherwise its falls set no flag and raise no irq.
- R7: While flag_mode=0, rd_data reads 0, writes are ignored and flags are held clear. Flags set earlier read 0 after flag_mode returns to 1.
- R8: irq is high for exactly one cycle per edge on which at least one new event registers, including when the flag of that line was already set. A rising edge raises no event.
- R9: Enabling a line whose level is already low raises no event. Only a later fall does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_in | input | 6 | Asynchronous key lines, idle high |
| pin_dir | input | 6 | Per-line port direction, 1 = input |
| pin_analog | input | 6 | Per-line mode control, 1 = analog, 0 = digital |
| flag_mode | input | 1 | 1 = keep per-line flags and allow register access |
| wr_en | input | 1 | Single-cycle write strobe for the flag register |
| wr_data | input | 8 | Write data; 0 clears the flag at that position |
| rd_data | output | 8 | Flag register read value (combinational) |
| irq | output | 1 | One-cycle combined key interrupt request |

## Verification
A new event and a software clear of the same flag can land on the same clock edge. The bench provokes this directly by timing a clear write so that it coincides with the edge on which a fall registers. It judges the outcome by the flag reading 1 afterwards and irq pulsing in that cycle. Random key activity mixed with random clear writes hits the same collision repeatedly, and every cycle is compared against a bench reference model.

// File: rtl/keyret_pkg.sv
package keyret_pkg;
    typedef enum logic [1:0] {
        KS_OFF  = 2'd0,
        KS_HIGH = 2'd1,
        KS_LOW  = 2'd2
    } key_state_t;
endpackage

// File: rtl/keyret_sync.sv
module keyret_sync #(
    parameter int STAGES = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/keyret_line_fsm.sv
module keyret_line_fsm
    import keyret_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_en,
    input  logic level,
    output logic fall_evt
);
    key_state_t state, nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= KS_OFF;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            KS_OFF: begin
                if (line_en) nxt = level ? KS_HIGH : KS_LOW;
            end
            KS_HIGH: begin
                if (!line_en)   nxt = KS_OFF;
                else if (!level) nxt = KS_LOW;
            end
            KS_LOW: begin
                if (!line_en)   nxt = KS_OFF;
                else if (level) nxt = KS_HIGH;
            end
            default: nxt = KS_OFF;
        endcase
    end

    // outputs
    always_comb begin
        fall_evt = 1'b0;
        unique case (state)
            KS_HIGH: fall_evt = line_en && !level;
            KS_OFF, KS_LOW: fall_evt = 1'b0;
            default: fall_evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/keyret_flags.sv
module keyret_flags #(
    parameter int NUM_KEYS = 6,
    parameter int REG_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] evt,
    input  logic                flag_mode,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    output logic                irq
);
    logic [NUM_KEYS-1:0] flags, flags_nxt, keep_mask;

    always_comb begin
        keep_mask = wr_en ? wr_data[NUM_KEYS-1:0] : {NUM_KEYS{1'b1}};
        // a new event overrides a clear in the same cycle
        flags_nxt = flag_mode ? ((flags & keep_mask) | evt) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            irq   <= 1'b0;
        end else begin
            flags <= flags_nxt;
            irq   <= |evt;
        end
    end

    assign rd_data[NUM_KEYS-1:0] = flag_mode ? flags : '0;

    generate
        if (REG_W > NUM_KEYS) begin : g_pad
            assign rd_data[REG_W-1:NUM_KEYS] = '0;
        end
    endgenerate
endmodule

// File: rtl/keyret_capture.sv
module keyret_capture #(
    parameter int NUM_KEYS    = 6,
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] key_in,
    input  logic [NUM_KEYS-1:0] pin_dir,
    input  logic [NUM_KEYS-1:0] pin_analog,
    input  logic                flag_mode,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    output logic                irq
);
    logic [NUM_KEYS-1:0] line_en;
    logic [NUM_KEYS-1:0] level;
    logic [NUM_KEYS-1:0] evt;

    assign line_en = pin_dir & ~pin_analog;

    generate
        for (genvar i = 0; i < NUM_KEYS; i++) begin : g_line
            keyret_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .d_async (key_in[i]),
                .q_sync  (level[i])
            );
            keyret_line_fsm u_fsm (
                .clk      (clk),
                .rst_n    (rst_n),
                .line_en  (line_en[i]),
                .level    (level[i]),
                .fall_evt (evt[i])
            );
        end
    endgenerate

    keyret_flags #(.NUM_KEYS(NUM_KEYS), .REG_W(REG_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .flag_mode (flag_mode),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .irq       (irq)
    );
endmodule

// File: rtl/keyret_capture_chk.sv
module keyret_capture_chk #(
    parameter int NUM_KEYS = 6,
    parameter int REG_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_KEYS-1:0] pin_dir,
    input logic [NUM_KEYS-1:0] pin_analog,
    input logic                flag_mode,
    input logic                wr_en,
    input logic [REG_W-1:0]    rd_data,
    input logic                irq
);
    // R3
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:NUM_KEYS] == '0);

    // R7
    mode_off_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_mode |-> rd_data == '0);

    // R4
    no_clear_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_mode && !wr_en) |=>
            (!flag_mode || ((rd_data[NUM_KEYS-1:0] & $past(rd_data[NUM_KEYS-1:0]))
                            == $past(rd_data[NUM_KEYS-1:0]))));

    // R2
    new_flag_has_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_mode && $past(flag_mode) &&
         ((rd_data[NUM_KEYS-1:0] & ~$past(rd_data[NUM_KEYS-1:0])) != '0)) |-> irq);

    // R6
    irq_needs_enabled_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|(pin_dir & ~pin_analog)));
endmodule

bind keyret_capture keyret_capture_chk #(.NUM_KEYS(NUM_KEYS), .REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_dir    (pin_dir),
    .pin_analog (pin_analog),
    .flag_mode  (flag_mode),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .irq        (irq)
);

// File: tb/keyret_capture_bench.sv
module keyret_capture_bench;
    localparam int N = 6;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] key_in = '1;
    logic [N-1:0] pin_dir = '0;
    logic [N-1:0] pin_analog = '0;
    logic         flag_mode = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    keyret_capture u_keyret_capture (
        .clk(clk), .rst_n(rst_n), .key_in(key_in), .pin_dir(pin_dir),
        .pin_analog(pin_analog), .flag_mode(flag_mode), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // reference model built from the requirements (R2 latency, R4/R5 priority, R7 mode)
    logic [N-1:0] m_s1, m_s2, m_prev, m_armed, m_flags;
    logic         m_irq;

    function automatic logic [N-1:0] new_events(input logic [N-1:0] armed,
        input logic [N-1:0] en, input logic [N-1:0] prev, input logic [N-1:0] lvl);
        return armed & en & prev & ~lvl;
    endfunction

    function automatic logic [W-1:0] expect_rd(input logic mode, input logic [N-1:0] f);
        return mode ? {{(W-N){1'b0}}, f} : '0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '1; m_s2 <= '1; m_prev <= '1; m_armed <= '0;
            m_flags <= '0; m_irq <= 1'b0;
        end else begin
            logic [N-1:0] en, ev, keep;
            en   = pin_dir & ~pin_analog;
            ev   = new_events(m_armed, en, m_prev, m_s2);
            keep = wr_en ? wr_data[N-1:0] : '1;
            m_flags <= flag_mode ? ((m_flags & keep) | ev) : '0;
            m_irq   <= |ev;
            m_armed <= en;
            m_prev  <= m_s2;
            m_s2    <= m_s1;
            m_s1    <= key_in;
        end
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n) begin
            check({phase, " rd_data"}, rd_data, expect_rd(flag_mode, m_flags));
            check({phase, " irq"}, {7'd0, irq}, {7'd0, m_irq});
            check("R3 upper bits", {6'd0, rd_data[7:6]}, 8'h00);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        tick(3);
        // R1 reset state
        check("R1 reset rd", rd_data, 8'h00);
        check("R1 reset irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        pin_dir = '1; pin_analog = '0; flag_mode = 1'b1;
        tick(4);

        // R2 single fall on line 0: flag after 3rd edge
        phase = "R2";
        key_in[0] = 1'b0;
        tick(2);
        check("R2 not yet", rd_data, 8'h00);
        @(negedge clk);
        check("R2 flag0", rd_data, 8'h01);
        check("R2 irq", {7'd0, irq}, 8'h01);
        #1; tick(1);
        check("R8 irq one cycle", {7'd0, irq}, 8'h00);

        // set lines 1,2,5 then clear only line 2 (R4)
        phase = "R4";
        key_in[1] = 0; key_in[2] = 0; key_in[5] = 0;
        tick(4);
        check("R4 setup", rd_data, 8'h27);
        wr_en = 1; wr_data = 8'hFB; tick(1); wr_en = 0;
        check("R4 selective clear", rd_data, 8'h23);
        wr_en = 1; wr_data = 8'hFF; tick(1); wr_en = 0;
        check("R4 write ones no effect", rd_data, 8'h23);

        // R8 re-fall on line 0 with flag already set
        phase = "R8";
        key_in[0] = 1; tick(4);
        check("R8 rise no irq", {7'd0, irq}, 8'h00);
        key_in[0] = 0; tick(3);
        check("R8 repeat irq", {7'd0, irq}, 8'h01);
        tick(1);

        // R5 collision of set and clear on line 3
        phase = "R5";
        key_in[3] = 0; tick(2);
        wr_en = 1; wr_data = 8'hF7; tick(1); wr_en = 0;
        check("R5 set wins", {7'd0, rd_data[3]}, 8'h01);

        // R6 disabled pins: line 4 analog, then line 4 output direction
        phase = "R6";
        wr_en = 1; wr_data = 8'h00; tick(1); wr_en = 0;
        pin_analog[4] = 1; key_in[4] = 0; tick(5);
        check("R6 analog no flag", rd_data, 8'h00);
        key_in[4] = 1; tick(3); pin_analog[4] = 0; pin_dir[4] = 0; tick(2);
        key_in[4] = 0; tick(5);
        check("R6 output dir no flag", rd_data, 8'h00);

        // R9 enabling a line that is already low
        phase = "R9";
        pin_dir[4] = 1; tick(6);
        check("R9 no event on enable", rd_data, 8'h00);
        key_in[4] = 1; tick(4); key_in[4] = 0; tick(4);
        check("R9 later fall sets", rd_data, 8'h10);

        // R7 flag mode off
        phase = "R7";
        flag_mode = 0; tick(1);
        check("R7 read zero", rd_data, 8'h00);
        wr_en = 1; wr_data = 8'hFF; tick(1); wr_en = 0;
        flag_mode = 1; tick(1);
        check("R7 flags dropped", rd_data, 8'h00);

        // random phase against the model
        phase = "random";
        for (int c = 0; c < 6000; c++) begin
            for (int b = 0; b < N; b++)
                if (($urandom % 8) == 0) key_in[b] = ~key_in[b];
            if (($urandom % 64) == 0) begin
                pin_dir = 6'($urandom) | 6'($urandom);
                pin_analog = 6'($urandom) & 6'($urandom);
            end
            if (($urandom % 40) == 0) flag_mode = ~flag_mode;
            if (!flag_mode && ($urandom % 4) == 0) flag_mode = 1;
            wr_en = (($urandom % 6) == 0);
            wr_data = 8'($urandom) | 8'($urandom);
            tick(1);
        end
        wr_en = 0;
        tick(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule